// File: doc/BRIEF.md
# Narrow-to-wide memory width adapter

This block connects a 32-bit processor-style memory port to a 64-bit memory port. The 64-bit memory is made of two 32-bit halves that share one address and one command. To the processor the memory looks 32 bits wide and twice as deep. Byte address bit 2 chooses which half a processor access targets. Memory bank, row and column are taken from the address bits above that select bit.

A 64-bit word is written in two processor writes: the lower half first, then the upper half. The lower-half write is stored in a holding register and acknowledged at once, with no memory cycle. The upper-half write is then merged with the held word, and one 64-bit write with a mask for each byte lane goes to memory. A lower-half read fetches the full 64-bit word, returns the lower half and keeps the upper half. An upper-half read to the same 64-bit word that follows is then answered from that buffer.

During a burst the block generates the beat addresses itself and keeps the first beat's byte enables for every beat. The halves therefore alternate, starting at an even word.

Top module: `wide_mem_adapter`

## Requirements
- R1: The memory address fields come from the processor byte address as follows: `mem_bank` = bits 25:24, `mem_row` = bits 23:12, `mem_col` = bits 11:3. Bit 2 is the half select, and bits 1:0 are a byte offset that does not reach memory.
- R2: A write with address bit 2 = 0 (lower half) is acknowledged on `cpu_ack` with no `mem_req`. Its data and byte enables are held.
- R3: A write with bit 2 = 1 to the same 64-bit word as a held lower write issues exactly one memory write. `mem_wdata` = {upper data, held lower data}, and `mem_be` = {upper enables, held lower enables}, where `mem_be[i]` enables byte lane i (bits 8i+7:8i).
- R4: `mem_we` is asserted only for upper-half writes. Lower-half writes never cause a memory write.
- R5: A read issues one memory read with `mem_be` all ones, unless R6 applies. `cpu_rdata` returns `mem_rdata[31:0]` when bit 2 = 0 and `mem_rdata[63:32]` when bit 2 = 1.
- R6: After a lower-half read, an upper-half read to the same 64-bit word returns the buffered upper half with no `mem_req`.
- R7: Any write to a 64-bit word discards the buffered upper half of that word. The next upper-half read of that word goes to memory.
- R8: An upper-half write with no held lower write for the same 64-bit word is sent with `mem_be[3:0]` = 0 and `mem_wdata[31:0]` = 0.
- R9: The held lower write is consumed by the merge. A second upper write to the same word gets lower lanes disabled.
- R10: Byte enables act per half on their own. A lower mask of 0000 followed by an upper mask of 0100 gives `mem_be` = 8'h40, which writes only byte 6.
- R11: While `cpu_burst` stays high, beat n after the first uses the first beat's address plus 4n and the first beat's byte enables. `cpu_addr` and `cpu_be` are ignored on those beats.
- R12: An accepted request with `cpu_burst` = 0 ends the burst and uses its own address.
- R13: `cpu_ack` is a one-cycle pulse, and `cpu_rdata` is valid while it is high. `mem_req` and the command stay stable until `mem_ack`. After reset, neither `cpu_ack` nor `mem_req` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_be | input | 4 | Byte enables for the 32-bit word |
| cpu_wdata | input | 32 | Write data |
| cpu_burst | input | 1 | High on every beat of a burst |
| cpu_ack | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write enable |
| mem_bank | output | 2 | Bank field |
| mem_row | output | 12 | Row field |
| mem_col | output | 9 | Column field |
| mem_wdata | output | 64 | 64-bit write data |
| mem_be | output | 8 | Byte-lane enables for the 64-bit word |
| mem_ack | input | 1 | Memory completion pulse, `mem_rdata` valid |
| mem_rdata | input | 64 | 64-bit read data |

## Verification
The assertions assume the processor side keeps `cpu_req` and its fields steady until `cpu_ack`, and that every burst starts at an even word address. They also assume the memory answers each request with a single `mem_ack` pulse. The directed tasks keep within these rules: each access waits for its acknowledge and drops the request in the same cycle, and bursts start at column-aligned addresses. The memory model answers after a fixed latency with a single `mem_ack` pulse.

// File: rtl/wma_pkg.sv
package wma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_ACK  = 2'd2
  } wma_state_e;
endpackage

// File: rtl/wma_addr_map.sv
module wma_addr_map #(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 32,
  parameter int COL_W  = 9,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2
) (
  input  logic [ADDR_W-1:0]             addr,
  output logic                          sel,
  output logic [COL_W+ROW_W+BANK_W-1:0] tag
);
  localparam int OFS_W    = $clog2(HALF_W/8);
  localparam int SEL_BIT  = OFS_W;
  localparam int COL_LSB  = SEL_BIT + 1;
  localparam int ROW_LSB  = COL_LSB + COL_W;
  localparam int BANK_LSB = ROW_LSB + ROW_W;
  localparam int TOP      = BANK_LSB + BANK_W;

  logic [COL_W-1:0]  col_f;
  logic [ROW_W-1:0]  row_f;
  logic [BANK_W-1:0] bank_f;

  // R1: word-select bit stripped, the rest split into fields
  assign sel    = addr[SEL_BIT];
  assign col_f  = addr[COL_LSB +: COL_W];
  assign row_f  = addr[ROW_LSB +: ROW_W];
  assign bank_f = addr[BANK_LSB +: BANK_W];
  assign tag    = {bank_f, row_f, col_f};

  logic unused_lo;
  assign unused_lo = ^addr[OFS_W-1:0];
  generate
    if (ADDR_W > TOP) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^addr[ADDR_W-1:TOP];
    end
  endgenerate
endmodule

// File: rtl/wma_burst_track.sv
module wma_burst_track #(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 32,
  parameter int BEAT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic                req_burst,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [HALF_W/8-1:0] req_be,
  output logic [ADDR_W-1:0]   eff_addr,
  output logic [HALF_W/8-1:0] eff_be
);
  localparam int LANES = HALF_W/8;
  localparam int OFS_W = $clog2(LANES);

  logic              active_q, active_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [ADDR_W-1:0] base_q;
  logic [LANES-1:0]  be_q;
  logic              load;
  logic              in_burst;
  logic [ADDR_W-1:0] step;

  always_comb begin
    active_d = active_q;
    beat_d   = beat_q;
    load     = 1'b0;
    if (accept) begin
      if (req_burst) begin
        if (!active_q) begin
          active_d = 1'b1;
          beat_d   = BEAT_W'(1);
          load     = 1'b1;
        end else begin
          beat_d = beat_q + BEAT_W'(1);
        end
      end else begin
        // R12: a plain request closes the burst
        active_d = 1'b0;
        beat_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else begin
      active_q <= active_d;
      beat_q   <= beat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      base_q <= req_addr;
      be_q   <= req_be;
    end
  end

  // R11: later beats use the generated address and the first mask
  assign in_burst = active_q && req_burst;
  assign step     = {{(ADDR_W-BEAT_W){1'b0}}, beat_q} << OFS_W;
  assign eff_addr = in_burst ? base_q + step : req_addr;
  assign eff_be   = in_burst ? be_q : req_be;

  // R11
  burst_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_burst && !active_q) |-> (req_addr[OFS_W] == 1'b0));

  // R11
  burst_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_burst && active_q) |=> $stable(be_q));
endmodule

// File: rtl/wma_write_hold.sv
module wma_write_hold #(
  parameter int HALF_W = 32,
  parameter int TAG_W  = 23
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_en,
  input  logic [HALF_W-1:0]   cap_data,
  input  logic [HALF_W/8-1:0] cap_be,
  input  logic [TAG_W-1:0]    cap_tag,
  input  logic                clr_en,
  output logic                pend,
  output logic [HALF_W-1:0]   hold_data,
  output logic [HALF_W/8-1:0] hold_be,
  output logic [TAG_W-1:0]    hold_tag
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (cap_en)      pend_d = 1'b1;
    else if (clr_en) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      hold_data <= cap_data;
      hold_be   <= cap_be;
      hold_tag  <= cap_tag;
    end
  end

  assign pend = pend_q;

  // R9
  clr_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> pend_q);

  // R9
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !cap_en) |=> !pend_q);

  // R2
  cap_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> pend_q);
endmodule

// File: rtl/wma_read_buf.sv
module wma_read_buf #(
  parameter int HALF_W = 32,
  parameter int TAG_W  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [HALF_W-1:0] fill_data,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic              inval_en,
  input  logic [TAG_W-1:0]  inval_tag,
  output logic              valid,
  output logic [HALF_W-1:0] buf_data,
  output logic [TAG_W-1:0]  buf_tag
);
  logic valid_q, valid_d;
  logic inval_hit;

  assign inval_hit = inval_en && (inval_tag == buf_tag);

  always_comb begin
    valid_d = valid_q;
    if (inval_hit)    valid_d = 1'b0;
    else if (fill_en) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      buf_data <= fill_data;
      buf_tag  <= fill_tag;
    end
  end

  assign valid = valid_q;

  // R6
  fill_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !inval_en) |=> valid_q);

  // R7
  inval_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_en && valid_q && (inval_tag == buf_tag) && !fill_en) |=> !valid_q);
endmodule

// File: rtl/wide_mem_adapter.sv
module wide_mem_adapter #(
  parameter int ADDR_W = 32,
  parameter int HALF_W = 32,
  parameter int COL_W  = 9,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int BEAT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [HALF_W/8-1:0]   cpu_be,
  input  logic [HALF_W-1:0]     cpu_wdata,
  input  logic                  cpu_burst,
  output logic                  cpu_ack,
  output logic [HALF_W-1:0]     cpu_rdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [BANK_W-1:0]     mem_bank,
  output logic [ROW_W-1:0]      mem_row,
  output logic [COL_W-1:0]      mem_col,
  output logic [2*HALF_W-1:0]   mem_wdata,
  output logic [2*HALF_W/8-1:0] mem_be,
  input  logic                  mem_ack,
  input  logic [2*HALF_W-1:0]   mem_rdata
);
  import wma_pkg::*;

  localparam int LANES = HALF_W/8;
  localparam int TAG_W = COL_W + ROW_W + BANK_W;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  wma_state_e        state_q, state_d;
  logic              accept;
  logic [ADDR_W-1:0] eff_addr;
  logic [LANES-1:0]  eff_be;
  logic              req_sel;
  logic [TAG_W-1:0]  req_tag;
  logic              lower_wr, upper_wr, rd_req, buf_hit, merge_ok;
  logic              pend;
  logic [HALF_W-1:0] hold_data;
  logic [LANES-1:0]  hold_be;
  logic [TAG_W-1:0]  hold_tag;
  logic              rb_valid;
  logic [HALF_W-1:0] rb_data;
  logic [TAG_W-1:0]  rb_tag;

  assign accept = (state_q == ST_IDLE) && cpu_req;

  wma_burst_track #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .BEAT_W(BEAT_W)) u_burst (
    .clk(clk), .rst_n(rst_n_s), .accept(accept), .req_burst(cpu_burst),
    .req_addr(cpu_addr), .req_be(cpu_be), .eff_addr(eff_addr), .eff_be(eff_be)
  );

  wma_addr_map #(.ADDR_W(ADDR_W), .HALF_W(HALF_W), .COL_W(COL_W),
                 .ROW_W(ROW_W), .BANK_W(BANK_W)) u_map (
    .addr(eff_addr), .sel(req_sel), .tag(req_tag)
  );

  assign lower_wr = accept && cpu_we && !req_sel;
  assign upper_wr = accept && cpu_we && req_sel;
  assign rd_req   = accept && !cpu_we;
  assign buf_hit  = rd_req && req_sel && rb_valid && (rb_tag == req_tag);
  assign merge_ok = pend && (hold_tag == req_tag);

  wma_write_hold #(.HALF_W(HALF_W), .TAG_W(TAG_W)) u_hold (
    .clk(clk), .rst_n(rst_n_s),
    .cap_en(lower_wr), .cap_data(cpu_wdata), .cap_be(eff_be), .cap_tag(req_tag),
    .clr_en(upper_wr && merge_ok),
    .pend(pend), .hold_data(hold_data), .hold_be(hold_be), .hold_tag(hold_tag)
  );

  // command registers
  logic                 cmd_load;
  logic                 cmd_we_q, cmd_sel_q;
  logic [TAG_W-1:0]     cmd_tag_q;
  logic [2*HALF_W-1:0]  cmd_wdata_q, cmd_wdata_d;
  logic [2*LANES-1:0]   cmd_be_q, cmd_be_d;
  logic                 rd_done;
  logic                 rdata_load;
  logic [HALF_W-1:0]    rdata_q, rdata_d;

  assign cmd_load = accept && !lower_wr && !buf_hit;

  always_comb begin
    // R3 / R8: merge with the held lower word or leave its lanes off
    cmd_wdata_d = {cpu_wdata, merge_ok ? hold_data : {HALF_W{1'b0}}};
    if (cpu_we) cmd_be_d = {eff_be, merge_ok ? hold_be : {LANES{1'b0}}};
    else        cmd_be_d = {(2*LANES){1'b1}};
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cpu_req) state_d = (lower_wr || buf_hit) ? ST_ACK : ST_MEM;
      ST_MEM:  if (mem_ack) state_d = ST_ACK;
      ST_ACK:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (cmd_load) begin
      cmd_we_q    <= cpu_we;
      cmd_sel_q   <= req_sel;
      cmd_tag_q   <= req_tag;
      cmd_wdata_q <= cmd_wdata_d;
      cmd_be_q    <= cmd_be_d;
    end
  end

  // R5: pick the half named by the select bit
  assign rd_done    = (state_q == ST_MEM) && mem_ack && !cmd_we_q;
  assign rdata_load = buf_hit || rd_done;
  always_comb begin
    if (buf_hit)        rdata_d = rb_data;
    else if (cmd_sel_q) rdata_d = mem_rdata[2*HALF_W-1:HALF_W];
    else                rdata_d = mem_rdata[HALF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rdata_load) rdata_q <= rdata_d;
  end

  wma_read_buf #(.HALF_W(HALF_W), .TAG_W(TAG_W)) u_rbuf (
    .clk(clk), .rst_n(rst_n_s),
    .fill_en(rd_done && !cmd_sel_q), .fill_data(mem_rdata[2*HALF_W-1:HALF_W]),
    .fill_tag(cmd_tag_q),
    .inval_en(accept && cpu_we), .inval_tag(req_tag),
    .valid(rb_valid), .buf_data(rb_data), .buf_tag(rb_tag)
  );

  assign cpu_ack   = (state_q == ST_ACK);
  assign cpu_rdata = rdata_q;
  assign mem_req   = (state_q == ST_MEM);
  // R4: memory write gated by the upper-half select
  assign mem_we    = mem_req && cmd_we_q && cmd_sel_q;
  assign mem_bank  = cmd_tag_q[TAG_W-1 -: BANK_W];
  assign mem_row   = cmd_tag_q[COL_W +: ROW_W];
  assign mem_col   = cmd_tag_q[COL_W-1:0];
  assign mem_wdata = cmd_wdata_q;
  assign mem_be    = cmd_be_q;

  // R2
  lowwr_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    lower_wr |=> (cpu_ack && !mem_req));

  // R6
  bufhit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    buf_hit |=> (cpu_ack && !mem_req));

  // R13
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    cpu_ack |=> !cpu_ack);

  // R13
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_col)
                               && $stable(mem_row) && $stable(mem_bank)
                               && $stable(mem_be) && $stable(mem_wdata)));
endmodule

// File: tb/wide_mem_adapter_tb_top.sv
module wide_mem_adapter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we, cpu_burst;
  logic [31:0] cpu_addr, cpu_wdata;
  logic [3:0]  cpu_be;
  logic        cpu_ack;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [1:0]  mem_bank;
  logic [11:0] mem_row;
  logic [8:0]  mem_col;
  logic [63:0] mem_wdata, mem_rdata;
  logic [7:0]  mem_be;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int mem_cnt = 0;
  int wait_q = 0;
  logic        last_we;
  logic [7:0]  last_be;
  logic [63:0] last_wdata;
  logic [1:0]  last_bank;
  logic [11:0] last_row;
  logic [8:0]  last_col;
  logic [63:0] model_q [0:255];

  always #5 clk = ~clk;

  wide_mem_adapter dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_burst(cpu_burst),
    .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank), .mem_row(mem_row),
    .mem_col(mem_col), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory model: fixed latency, byte-lane writes, indexed by column low bits
  always @(posedge clk or negedge rst_n) begin : mdl
    logic [63:0] nv;
    if (!rst_n) begin
      mem_ack <= 1'b0;
      wait_q  <= 0;
      for (int i = 0; i < 256; i++) model_q[i] <= 64'h0;
      model_q[8'h55] <= 64'hCAFEF00D_12345678;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wait_q == 2) begin
          wait_q     <= 0;
          mem_ack    <= 1'b1;
          mem_rdata  <= model_q[mem_col[7:0]];
          mem_cnt    <= mem_cnt + 1;
          last_we    <= mem_we;
          last_be    <= mem_be;
          last_wdata <= mem_wdata;
          last_bank  <= mem_bank;
          last_row   <= mem_row;
          last_col   <= mem_col;
          if (mem_we) begin
            nv = model_q[mem_col[7:0]];
            for (int b = 0; b < 8; b++)
              if (mem_be[b]) nv[b*8 +: 8] = mem_wdata[b*8 +: 8];
            model_q[mem_col[7:0]] <= nv;
          end
        end else begin
          wait_q <= wait_q + 1;
        end
      end
    end
  end

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
      report();
      $finish;
    end
  end

  task automatic check_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input logic burst, output logic [31:0] rd);
    @(negedge clk);
    cpu_we = we; cpu_addr = addr; cpu_be = be; cpu_wdata = wd; cpu_burst = burst;
    cpu_req = 1'b1;
    do @(negedge clk); while (!cpu_ack);
    rd = cpu_rdata;
    cpu_req = 1'b0;
    @(negedge clk);
    check_eq("R13 ack pulse width", {63'h0, cpu_ack}, 64'h0);
  endtask

  task automatic t_reset();
    check_eq("R13 reset ack", {63'h0, cpu_ack}, 64'h0);
    check_eq("R13 reset mem_req", {63'h0, mem_req}, 64'h0);
  endtask

  task automatic t_addr_map();
    logic [31:0] rd;
    int c0 = mem_cnt;
    access(1'b0, 32'h02AB_CAAC, 4'hF, 32'h0, 1'b0, rd);
    check_eq("R1 bank", {62'h0, last_bank}, 64'h2);
    check_eq("R1 row", {52'h0, last_row}, 64'hABC);
    check_eq("R1 col", {55'h0, last_col}, 64'h155);
    check_eq("R5 read be all ones", {56'h0, last_be}, 64'hFF);
    check_eq("R5 upper half returned", {32'h0, rd}, 64'hCAFEF00D);
    check_eq("R5 one memory read", mem_cnt - c0, 1);
  endtask

  task automatic t_merge_write();
    logic [31:0] rd;
    int c0 = mem_cnt;
    access(1'b1, 32'h28, 4'hF, 32'h11223344, 1'b0, rd);
    check_eq("R2 lower write no memory", mem_cnt - c0, 0);
    access(1'b1, 32'h2C, 4'hF, 32'h55667788, 1'b0, rd);
    check_eq("R3 single memory write", mem_cnt - c0, 1);
    check_eq("R4 write enable on upper", {63'h0, last_we}, 64'h1);
    check_eq("R3 merged data", last_wdata, 64'h55667788_11223344);
    check_eq("R3 merged mask", {56'h0, last_be}, 64'hFF);
    check_eq("R3 column", {55'h0, last_col}, 64'h5);
  endtask

  task automatic t_read_buffer();
    logic [31:0] rd;
    int c0 = mem_cnt;
    access(1'b0, 32'h28, 4'hF, 32'h0, 1'b0, rd);
    check_eq("R5 lower half returned", {32'h0, rd}, 64'h11223344);
    check_eq("R4 read has no write enable", {63'h0, last_we}, 64'h0);
    access(1'b0, 32'h2C, 4'hF, 32'h0, 1'b0, rd);
    check_eq("R6 upper from buffer data", {32'h0, rd}, 64'h55667788);
    check_eq("R6 no memory access", mem_cnt - c0, 1);
  endtask

  task automatic t_byte6();
    logic [31:0] rd;
    int c0 = mem_cnt;
    access(1'b1, 32'h28, 4'h0, 32'hDEADBEEF, 1'b0, rd);
    check_eq("R2 masked lower no memory", mem_cnt - c0, 0);
    access(1'b1, 32'h2C, 4'h4, 32'h00AB0000, 1'b0, rd);
    check_eq("R10 byte 6 mask", {56'h0, last_be}, 64'h40);
    access(1'b0, 32'h2C, 4'hF, 32'h0, 1'b0, rd);
    check_eq("R7 upper read refetched", mem_cnt - c0, 2);
    check_eq("R10 byte 6 written", {32'h0, rd}, 64'h55AB7788);
  endtask

  task automatic t_no_pending();
    logic [31:0] rd;
    access(1'b1, 32'h2C, 4'hF, 32'h99999999, 1'b0, rd);
    check_eq("R9 merge consumed mask", {56'h0, last_be}, 64'hF0);
    check_eq("R9 lower data zero", {32'h0, last_wdata[31:0]}, 64'h0);
    access(1'b1, 32'h3C, 4'hF, 32'h77777777, 1'b0, rd);
    check_eq("R8 fresh upper mask", {56'h0, last_be}, 64'hF0);
    access(1'b1, 32'h60, 4'h3, 32'hC0C0C0C0, 1'b0, rd);
    access(1'b1, 32'h6C, 4'hF, 32'hD0D0D0D0, 1'b0, rd);
    check_eq("R8 other word mask", {56'h0, last_be}, 64'hF0);
    access(1'b1, 32'h64, 4'hF, 32'hC1C1C1C1, 1'b0, rd);
    check_eq("R3 held word still merges", {56'h0, last_be}, 64'hF3);
    check_eq("R3 held data", last_wdata, 64'hC1C1C1C1_C0C0C0C0);
  endtask

  task automatic t_burst();
    logic [31:0] rd;
    int c0 = mem_cnt;
    access(1'b1, 32'h48, 4'hF, 32'hA0A0A0A0, 1'b1, rd);
    access(1'b1, 32'hFFF0, 4'h0, 32'hA1A1A1A1, 1'b1, rd);
    check_eq("R11 beat1 column", {55'h0, last_col}, 64'h9);
    check_eq("R11 beat1 mask kept", {56'h0, last_be}, 64'hFF);
    check_eq("R11 beat1 data", last_wdata, 64'hA1A1A1A1_A0A0A0A0);
    access(1'b1, 32'h0, 4'h2, 32'hA2A2A2A2, 1'b1, rd);
    access(1'b1, 32'h0, 4'h0, 32'hA3A3A3A3, 1'b1, rd);
    check_eq("R11 beat3 column", {55'h0, last_col}, 64'hA);
    check_eq("R11 beat3 data", last_wdata, 64'hA3A3A3A3_A2A2A2A2);
    check_eq("R11 two memory writes", mem_cnt - c0, 2);
    access(1'b0, 32'h48, 4'hF, 32'h0, 1'b0, rd);
    check_eq("R12 plain read own address", {32'h0, rd}, 64'hA0A0A0A0);
    check_eq("R12 column", {55'h0, last_col}, 64'h9);
    access(1'b0, 32'h50, 4'hF, 32'h0, 1'b1, rd);
    check_eq("R11 read burst beat0", {32'h0, rd}, 64'hA2A2A2A2);
    c0 = mem_cnt;
    access(1'b0, 32'hFF00, 4'hF, 32'h0, 1'b1, rd);
    check_eq("R11 read burst beat1", {32'h0, rd}, 64'hA3A3A3A3);
    check_eq("R6 burst upper from buffer", mem_cnt - c0, 0);
    access(1'b0, 32'h28, 4'hF, 32'h0, 1'b0, rd);
    check_eq("R12 burst closed", {32'h0, rd}, 64'h11223344);
  endtask

  initial begin
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_burst = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; cpu_be = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_addr_map();
    t_merge_write();
    t_read_buffer();
    t_byte6();
    t_no_pending();
    t_burst();
    report();
    $finish;
  end
endmodule